// File: doc/BRIEF.md
# 8-Point DCT Vector Engine

This block computes the one-dimensional 8-point forward DCT of one vector of an 8x8 sample block. The block's vectors live in eight separate single-port memories, one per vector, and the engine works on the memory picked by a vector selector. A one-cycle start pulse launches the computation. The engine reads the eight 16-bit signed samples, forms the butterfly sums and differences, and accumulates them against constant cosine coefficients. It then writes the eight rounded results back over the samples they came from and raises a done pulse.

The memories return read data one cycle after the address. The engine therefore runs a fixed 17-step schedule. Steps 1 to 8 issue the reads in pair order. Steps 2, 4, 6 and 8 latch the first element of each pair as the seed. Steps 3, 5, 7 and 9 update all eight accumulators as the pair partner arrives. Steps 10 to 17 write the outputs back in element order. A surrounding controller runs the engine over the rows and then the columns of a block to form a two-dimensional transform.

Top module: `dct8_engine`

## Requirements
- R1: After reset `mem_rd`, `mem_wr` and `done` are low, and they stay low until a start is accepted.
- R2: A start taken while idle makes `mem_rd` high with `mem_addr` 0 in the next cycle. Eight reads follow on consecutive cycles at element addresses 0, 7, 1, 6, 2, 5, 3, 4.
- R3: A start pulse that arrives while a vector is in progress is ignored. It causes no extra reads, writes or done pulse, and it does not change the selected memory.
- R4: `vec_sel` is captured when a start is accepted. `mem_bank` carries that value on every read and write of the run.
- R5: Even outputs are formed from the pair sums s_p = x[p] + x[7-p], with A=45, B=59, C=24. Z0 = A(s0+s1+s2+s3). Z2 = B s0 + C s1 - C s2 - B s3. Z4 = A s0 - A s1 - A s2 + A s3. Z6 = C s0 - B s1 + B s2 - C s3.
- R6: Odd outputs are formed from the pair differences d_p = x[p] - x[7-p], with D=63, E=53, F=36, G=12. Z1 = D d0 + E d1 + F d2 + G d3. Z3 = E d0 - G d1 - D d2 - F d3. Z5 = F d0 - D d1 + G d2 + E d3. Z7 = G d0 - F d1 + E d2 - D d3.
- R7: The value stored for output k is (Zk + 64) shifted arithmetically right by 7, keeping the low 16 bits. Zk is accumulated in 20-bit two's complement, and inputs within ±1023 keep it from wrapping.
- R8: Nine cycles after the first read, eight writes follow on consecutive cycles. They store Z0 to Z7 at element addresses 0 to 7 in that order, and no read is issued during a write.
- R9: `done` is high for exactly one cycle, the cycle after the write of element 7. A start in that cycle is accepted.
- R10: Each accepted start clears all accumulators, so a vector's results do not depend on earlier vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to transform a vector |
| vec_sel | input | 3 | Memory (vector) to transform, captured at start |
| done | output | 1 | One-cycle completion pulse |
| mem_bank | output | 3 | Memory selected for the current access |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 3 | Element address within the vector |
| mem_wdata | output | 16 | Result written back |
| mem_rdata | input | 16 | Read data, valid one cycle after the read address |

## Verification
The bench builds the engine with its default parameters: 16-bit samples, a 20-bit accumulator, a 7-bit fraction, the default coefficient set and the shift-and-add product variant. With eight 3-bit-selected memories, the bench can show that one vector is processed while a second, prefilled memory stays untouched. The 20-bit width lets samples up to ±1000 be compared exactly against a direct cosine-sum reference, including the alternating full-swing vectors that drive the odd outputs hardest. The 17-step length of a run places the back-to-back restart on the done cycle, and the mid-run start lands while the writes are pending.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
   // Signed coefficient applied to pair p for output k (even k: sums, odd k: differences)
   function automatic int lane_coef(input int k, input int p,
                                    input int a, input int b, input int c, input int d,
                                    input int e, input int f, input int g);
      case (k)
         0: return a;
         1: case (p) 0: return d; 1: return e; 2: return f; default: return g; endcase
         2: case (p) 0: return b; 1: return c; 2: return -c; default: return -b; endcase
         3: case (p) 0: return e; 1: return -g; 2: return -d; default: return -f; endcase
         4: case (p) 0: return a; 1: return -a; 2: return -a; default: return a; endcase
         5: case (p) 0: return f; 1: return -d; 2: return g; default: return e; endcase
         6: case (p) 0: return c; 1: return -b; 2: return b; default: return -c; endcase
         default: case (p) 0: return g; 1: return -f; 2: return e; default: return -d; endcase
      endcase
   endfunction
endpackage

// File: rtl/dct8_seq.sv
module dct8_seq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       busy,
   output logic       clr,
   output logic       rd,
   output logic       wr,
   output logic       seed_ld,
   output logic       acc_en,
   output logic [1:0] pair,
   output logic [2:0] addr,
   output logic       done
);
   localparam int SW = 5;
   localparam logic [SW-1:0] S_RD_LAST  = SW'(8);
   localparam logic [SW-1:0] S_MAC_LAST = SW'(9);
   localparam logic [SW-1:0] S_WR_FIRST = SW'(10);
   localparam logic [SW-1:0] S_LAST     = SW'(17);

   logic [SW-1:0] s;
   logic [2:0]    i3;
   logic [2:0]    rd_addr;
   logic [2:0]    wr_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s    <= '0;
         done <= 1'b0;
      end else begin
         done <= (s == S_LAST);
         if (s == '0) begin
            if (start) s <= SW'(1);
         end else if (s == S_LAST) begin
            s <= '0;
         end else begin
            s <= s + SW'(1);
         end
      end
   end

   assign busy    = (s != '0);
   assign clr     = start && (s == '0);
   assign rd      = (s != '0) && (s <= S_RD_LAST);
   assign seed_ld = (s >= SW'(2)) && (s <= S_RD_LAST) && !s[0];
   assign acc_en  = (s >= SW'(3)) && (s <= S_MAC_LAST) && s[0];
   assign wr      = (s >= S_WR_FIRST) && (s <= S_LAST);
   assign pair    = s[2:1] - 2'd1;
   assign i3      = s[2:0] - 3'd1;
   assign rd_addr = i3[0] ? ~{1'b0, i3[2:1]} : {1'b0, i3[2:1]};
   assign wr_addr = s[2:0] - 3'd2;
   assign addr    = wr ? wr_addr : rd_addr;

   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr));
   a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (rd && addr == 3'd0));
   a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && s != S_LAST) |=> (s == $past(s) + SW'(1)));
   a_r8_wr_order: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr != 3'd7) |=> (wr && addr == $past(addr) + 3'd1));
   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr) && $past(addr) == 3'd7 && !wr));
endmodule

// File: rtl/dct8_lane.sv
module dct8_lane #(
   parameter int OW        = 17,
   parameter int AW        = 20,
   parameter int CW        = 8,
   parameter bit SHIFT_ADD = 1'b1,
   parameter int K0        = 0,
   parameter int K1        = 0,
   parameter int K2        = 0,
   parameter int K3        = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic [1:0]           pair,
   input  logic signed [OW-1:0] opnd,
   output logic signed [AW-1:0] acc
);
   function automatic logic signed [AW-1:0] shadd(input logic signed [OW-1:0] x, input int c);
      logic signed [AW-1:0] xe;
      logic signed [AW-1:0] r;
      int m;
      xe = AW'(x);
      r  = '0;
      m  = (c < 0) ? -c : c;
      for (int b = 0; b < CW; b++)
         if (m[b]) r = r + (xe <<< b);
      return (c < 0) ? -r : r;
   endfunction

   logic signed [AW-1:0] prod;

   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic signed [AW-1:0] pp [4];
         assign pp[0] = shadd(opnd, K0);
         assign pp[1] = shadd(opnd, K1);
         assign pp[2] = shadd(opnd, K2);
         assign pp[3] = shadd(opnd, K3);
         assign prod  = pp[pair];
      end else begin : g_multiply
         logic signed [CW-1:0] cf;
         logic signed [AW-1:0] ox;
         logic signed [AW-1:0] cx;
         always_comb begin
            case (pair)
               2'd0:    cf = CW'(K0);
               2'd1:    cf = CW'(K1);
               2'd2:    cf = CW'(K2);
               default: cf = CW'(K3);
            endcase
         end
         assign ox   = AW'(opnd);
         assign cx   = AW'(cf);
         assign prod = ox * cx;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + prod;
   end

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (acc == '0));
endmodule

// File: rtl/dct8_engine.sv
module dct8_engine
   import dct8_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 20,
   parameter int FRAC      = 7,
   parameter int CW        = 8,
   parameter int BANK_W    = 3,
   parameter bit SHIFT_ADD = 1'b1,
   parameter int COEF_A    = 45,
   parameter int COEF_B    = 59,
   parameter int COEF_C    = 24,
   parameter int COEF_D    = 63,
   parameter int COEF_E    = 53,
   parameter int COEF_F    = 36,
   parameter int COEF_G    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BANK_W-1:0] vec_sel,
   output logic              done,
   output logic [BANK_W-1:0] mem_bank,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [2:0]        mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata
);
   localparam int NPT = 8;
   localparam int OW  = DW + 1;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);

   generate
      if (AW < OW + 1)            begin : g_chk_aw   $error("accumulator narrower than operand"); end
      if (FRAC < 1 || FRAC >= AW) begin : g_chk_frac $error("fraction out of range"); end
      if (CW < 2 || CW > 16)      begin : g_chk_cw   $error("coefficient width out of range"); end
   endgenerate

   logic       busy, clr, seed_ld, acc_en;
   logic [1:0] pair;

   dct8_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .clr(clr),
      .rd(mem_rd), .wr(mem_wr), .seed_ld(seed_ld), .acc_en(acc_en),
      .pair(pair), .addr(mem_addr), .done(done)
   );

   logic signed [DW-1:0] seed;
   logic signed [OW-1:0] sum_w, dif_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seed     <= '0;
         mem_bank <= '0;
      end else begin
         if (seed_ld) seed <= mem_rdata;
         if (clr)     mem_bank <= vec_sel;
      end
   end

   assign sum_w = OW'(seed) + OW'($signed(mem_rdata));
   assign dif_w = OW'(seed) - OW'($signed(mem_rdata));

   logic signed [AW-1:0] acc_all [NPT];

   for (genvar k = 0; k < NPT; k++) begin : g_lane
      localparam int C0 = lane_coef(k, 0, COEF_A, COEF_B, COEF_C, COEF_D, COEF_E, COEF_F, COEF_G);
      localparam int C1 = lane_coef(k, 1, COEF_A, COEF_B, COEF_C, COEF_D, COEF_E, COEF_F, COEF_G);
      localparam int C2 = lane_coef(k, 2, COEF_A, COEF_B, COEF_C, COEF_D, COEF_E, COEF_F, COEF_G);
      localparam int C3 = lane_coef(k, 3, COEF_A, COEF_B, COEF_C, COEF_D, COEF_E, COEF_F, COEF_G);
      logic signed [OW-1:0] opnd;
      if (k % 2 == 0) begin : g_even
         assign opnd = sum_w;
      end else begin : g_odd
         assign opnd = dif_w;
      end
      dct8_lane #(
         .OW(OW), .AW(AW), .CW(CW), .SHIFT_ADD(SHIFT_ADD),
         .K0(C0), .K1(C1), .K2(C2), .K3(C3)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .clr(clr), .en(acc_en), .pair(pair),
         .opnd(opnd), .acc(acc_all[k])
      );
   end

   logic signed [AW-1:0] rsum;
   assign rsum      = acc_all[mem_addr] + HALF;
   assign mem_wdata = DW'(rsum >>> FRAC);

   a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(mem_bank)));
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> (!mem_rd && !mem_wr));
endmodule

// File: tb/sim_dct8_engine.sv
module sim_dct8_engine;
   localparam int CLK_PERIOD = 10;

   typedef struct packed { logic [2:0] addr; logic [15:0] data; } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  vec_sel = '0;
   logic        done, mem_rd, mem_wr;
   logic [2:0]  mem_bank, mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   logic [15:0] mem [8][8];
   wr_item_t    exp_q [$];
   int          total = 0, bad = 0, rd_idx = 0, done_cnt = 0, exp_bank = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dct8_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_sel(vec_sel), .done(done),
      .mem_bank(mem_bank), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_bank][mem_addr];
      if (mem_wr) mem[mem_bank][mem_addr] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int coefb(input int k, input int n);
      real c;
      c = (k == 0) ? 0.7071067811865476 : 1.0;
      return int'(64.0 * c * $cos(real'((2*n+1)*k) * 3.141592653589793 / 16.0));
   endfunction

   function automatic int order_of(input int i);
      return (i % 2 == 0) ? i / 2 : 7 - i / 2;
   endfunction

   // monitor: pops expected writes and checks reads, bank and done
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_rd) begin
            if (rd_idx >= 8) chk(1'b0, "R2 extra read", rd_idx, 7);
            else chk(mem_addr == 3'(order_of(rd_idx)), "R2 read order", mem_addr, order_of(rd_idx));
            chk(mem_bank == 3'(exp_bank), "R4 read bank", mem_bank, exp_bank);
            rd_idx++;
         end
         if (mem_wr) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected write", mem_addr, 0);
            else begin
               wr_item_t it;
               it = exp_q.pop_front();
               chk(mem_addr == it.addr, "R8 write address", mem_addr, it.addr);
               chk(mem_wdata == it.data, it.addr[0] ? "R6 R7 odd result" : "R5 R7 even result",
                   $signed(mem_wdata), $signed(it.data));
               chk(mem_bank == 3'(exp_bank), "R4 write bank", mem_bank, exp_bank);
            end
         end
         if (done) done_cnt++;
      end
   end

   task automatic launch(input int bank, input int v[8]);
      for (int n = 0; n < 8; n++) mem[bank][n] = 16'(v[n]);
      for (int k = 0; k < 8; k++) begin
         int z;
         wr_item_t it;
         z = 0;
         for (int n = 0; n < 8; n++) z += coefb(k, n) * v[n];
         it.addr = 3'(k);
         it.data = 16'((z + 64) >>> 7);
         exp_q.push_back(it);
      end
      exp_bank = bank;
      rd_idx   = 0;
      vec_sel  = 3'(bank);
      start    = 1'b1;
      @(negedge clk);
      start    = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 60) begin
         @(negedge clk);
         n++;
      end
      chk(done, req, n, 18);
   endtask

   task automatic run(input int bank, input int v[8], input string req);
      launch(bank, v);
      wait_done(req);
      @(negedge clk);
      chk(!done, "R9 done one cycle", done, 0);
      chk(exp_q.size() == 0, "R8 all writes seen", exp_q.size(), 0);
      chk(rd_idx == 8, "R2 eight reads", rd_idx, 8);
   endtask

   initial begin
      #(CLK_PERIOD * 40000);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v[8];
      int w[8];
      int d0;
      logic [15:0] save [8];
      for (int b = 0; b < 8; b++) for (int n = 0; n < 8; n++) mem[b][n] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(!done && !mem_rd && !mem_wr, "R1 reset quiet", {done, mem_rd, mem_wr}, 0);
      end

      v = '{0, 0, 0, 0, 0, 0, 0, 0};              run(0, v, "R5 zeros");
      v = '{100, 100, 100, 100, 100, 100, 100, 100}; run(1, v, "R5 constant");
      v = '{1000, -1000, 1000, -1000, 1000, -1000, 1000, -1000}; run(2, v, "R6 alternating");
      v = '{-350, -250, -150, -50, 50, 150, 250, 350}; run(3, v, "R6 ramp");
      v = '{-3, 0, 0, 0, 0, 0, 0, 0};             run(0, v, "R7 negative rounding");
      v = '{2, 0, 0, 0, 0, 0, 0, 1};              run(1, v, "R7 small rounding");
      v = '{0, 0, 0, 0, 0, 0, 0, -1000};          run(2, v, "R6 impulse last");
      for (int r = 0; r < 6; r++) begin
         for (int n = 0; n < 8; n++) v[n] = int'($urandom_range(0, 2000)) - 1000;
         run(r % 8, v, "R5 R6 random");
      end

      // R3: start during a run is ignored, bank 5 untouched
      for (int n = 0; n < 8; n++) begin mem[5][n] = 16'(n * 111 + 7); save[n] = mem[5][n]; end
      d0 = done_cnt;
      v = '{10, -20, 30, -40, 50, -60, 70, -80};
      launch(4, v);
      repeat (4) @(negedge clk);
      vec_sel = 3'd5; start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      vec_sel = 3'd5; start = 1'b1; @(negedge clk); start = 1'b0;
      wait_done("R3 run completes");
      repeat (25) @(negedge clk);
      chk(done_cnt == d0 + 1, "R3 single done", done_cnt - d0, 1);
      chk(rd_idx == 8, "R3 no extra reads", rd_idx, 8);
      for (int n = 0; n < 8; n++) chk(mem[5][n] == save[n], "R3 R4 other bank untouched", mem[5][n], save[n]);

      // R9/R10: restart on the done cycle, results independent
      v = '{900, 800, -700, 600, -500, 400, 300, -200};
      w = '{1, 2, 3, 4, 5, 6, 7, 8};
      launch(6, v);
      wait_done("R9 first of pair");
      launch(7, w);
      chk(rd_idx == 0 || rd_idx == 1, "R9 restart accepted", rd_idx, 1);
      wait_done("R10 second of pair");
      @(negedge clk);
      chk(exp_q.size() == 0, "R10 all writes seen", exp_q.size(), 0);
      for (int n = 0; n < 8; n++) begin
         int z;
         z = 0;
         for (int m = 0; m < 8; m++) z += coefb(n, m) * w[m];
         chk(mem[7][n] == 16'((z + 64) >>> 7), "R8 R10 in place", $signed(mem[7][n]), (z + 64) >>> 7);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule